// File: doc/BRIEF.md
# Programmable Flag Offset Register Loader

This block holds the two threshold offsets that a FIFO's flag generator uses: the almost-empty distance `n` and the almost-full distance `m`. Both are presented continuously at the outputs. During master reset the level of a load-select input is captured. That captured level fixes how the offsets may be written until the next master reset, and it also sets the value both offsets start from.

With the select high at reset, writes use the serial method. Bits arrive one per enabled clock, least significant first. The first `OFS_W` bits fill the empty offset and the next `OFS_W` bits fill the full offset. Each register takes its new value on the clock that delivers its last bit. With the select low at reset, writes use the parallel method. Each strobe carries a whole word. A write pointer alternates between the empty offset and the full offset, and it starts on the empty offset.

In either mode the offsets can be read back only through the parallel read port. That port has its own alternating pointer. Any value beyond half the FIFO depth is stored as exactly half the depth.

Top module: `ofs_loader`

## Requirements
- R1: The level of `load_sel_i` sampled on clock edges while `mrst` is high selects the mode: 1 = serial, 0 = parallel. The mode appears on `serial_mode_o` and does not change while `mrst` is low, whatever `load_sel_i` does.
- R2: After a reset in serial mode, both offsets equal 0x3FF.
- R3: After a reset in parallel mode, both offsets equal 0x07F.
- R4: In parallel mode, each `par_wr_i` strobe loads `par_wdata_i` into the empty offset and the full offset in turn, beginning with the empty offset. The offsets can be rewritten any number of times.
- R5: In serial mode, each `ser_en_i` clock shifts in `ser_bit_i`, least significant bit first. The empty offset changes only on the clock carrying bit `OFS_W`-1 of its word. The full offset changes only on the clock carrying the last bit of the second word. After that, the sequence starts again with the empty offset.
- R6: `par_rdata_o` shows the empty offset, then the full offset, then the empty offset again, advancing on each `par_rd_i` clock. Its pointer starts on the empty offset and is independent of the write pointer. Readback works in both modes.
- R7: A written or shifted value greater than 2^(`OFS_W`-1) is stored as 2^(`OFS_W`-1). Smaller values are stored unchanged.
- R8: In serial mode, `par_wr_i` strobes leave both offsets unchanged. In parallel mode, `ser_en_i` clocks leave both offsets unchanged.
- R9: Master reset restores the default values for the newly sampled mode and returns both pointers and the serial bit count to the empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high |
| load_sel_i | input | 1 | Method select, sampled only during master reset |
| par_wr_i | input | 1 | Parallel write strobe |
| par_wdata_i | input | OFS_W | Parallel write word |
| par_rd_i | input | 1 | Parallel read advance |
| par_rdata_o | output | OFS_W | Offset selected by the read pointer |
| ser_en_i | input | 1 | Serial shift enable |
| ser_bit_i | input | 1 | Serial data bit |
| serial_mode_o | output | 1 | Captured mode, 1 = serial |
| empty_ofs_o | output | OFS_W | Almost-empty offset n |
| full_ofs_o | output | OFS_W | Almost-full offset m |

## Verification
A wrong pointer or bit-count state shows up as a value landing in the other offset. It becomes visible on `empty_ofs_o`/`full_ofs_o` one clock after the strobe that misuses it, or on `par_rdata_o` as soon as the read pointer moves. A bit count that is off by one shows up as a commit one clock early or late, or as a word shifted by one bit position. The directed sequences therefore check the outputs on the clock just before each commit and on the commit clock itself. A wrongly captured mode shows at once on `serial_mode_o`, and one clock later as defaults that do not match the mode.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;

  // Default offset chosen by the load method captured at reset.
  function automatic logic [31:0] default_ofs(input load_mode_e mode);
    return (mode == LOAD_SER) ? 32'h0000_03FF : 32'h0000_007F;
  endfunction

  // Saturate an offset to the legal ceiling (half the depth).
  function automatic logic [31:0] clamp_ofs(input logic [31:0] value,
                                            input logic [31:0] ceiling);
    return (value > ceiling) ? ceiling : value;
  endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
  import ofs_pkg::*;
(
  input  logic       clk,
  input  logic       mrst,
  input  logic       sel_i,
  output load_mode_e mode_o
);

  always_ff @(posedge clk) begin
    if (mrst) mode_o <= sel_i ? LOAD_SER : LOAD_PAR;
  end

  // R1: the captured mode holds while reset is low
  a_r1_mode_held: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> $stable(mode_o));

endmodule

// File: rtl/ofs_serial_shifter.sv
module ofs_serial_shifter #(
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [OFS_W-1:0] word_o,
  output logic             last_n_o,
  output logic             last_m_o
);

  localparam int TOTAL = 2 * OFS_W;
  localparam int CW    = $clog2(TOTAL);
  localparam logic [CW-1:0] IDX_LAST_N = CW'(OFS_W - 1);
  localparam logic [CW-1:0] IDX_LAST_M = CW'(TOTAL - 1);

  logic [OFS_W-1:0] shreg;
  logic [CW-1:0]    bit_cnt;

  // The word includes the bit arriving this cycle in its top position.
  assign word_o   = {bit_i, shreg[OFS_W-1:1]};
  assign last_n_o = en_i && (bit_cnt == IDX_LAST_N);
  assign last_m_o = en_i && (bit_cnt == IDX_LAST_M);

  always_ff @(posedge clk) begin
    if (mrst) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (en_i) begin
      shreg   <= word_o;
      bit_cnt <= (bit_cnt == IDX_LAST_M) ? '0 : bit_cnt + 1'b1;
    end
  end

  // R5: the bit count never leaves the two-word window
  a_r5_count_range: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |-> (bit_cnt <= IDX_LAST_M));

  // R5: after the last bit of the full offset the count is back at zero
  a_r5_wrap: assert property (@(posedge clk) disable iff (mrst)
    last_m_o |=> (bit_cnt == '0));

endmodule

// File: rtl/ofs_par_port.sv
module ofs_par_port #(
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [OFS_W-1:0] n_i,
  input  logic [OFS_W-1:0] m_i,
  output logic             wr_to_m_o,
  output logic [OFS_W-1:0] rdata_o
);

  logic rd_at_m;

  always_ff @(posedge clk) begin
    if (mrst) begin
      wr_to_m_o <= 1'b0;
      rd_at_m   <= 1'b0;
    end else begin
      if (wr_i) wr_to_m_o <= ~wr_to_m_o;
      if (rd_i) rd_at_m   <= ~rd_at_m;
    end
  end

  assign rdata_o = rd_at_m ? m_i : n_i;

  // R6: each read advance moves the read pointer
  a_r6_rd_toggle: assert property (@(posedge clk) disable iff (mrst)
    rd_i |=> (rd_at_m != $past(rd_at_m)));

  // R6: without an advance the read pointer holds
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (mrst)
    !rd_i |=> $stable(rd_at_m));

  // R4: each accepted write moves the write pointer
  a_r4_wr_toggle: assert property (@(posedge clk) disable iff (mrst)
    wr_i |=> (wr_to_m_o != $past(wr_to_m_o)));

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             load_sel_i,
  input  logic             par_wr_i,
  input  logic [OFS_W-1:0] par_wdata_i,
  input  logic             par_rd_i,
  output logic [OFS_W-1:0] par_rdata_o,
  input  logic             ser_en_i,
  input  logic             ser_bit_i,
  output logic             serial_mode_o,
  output logic [OFS_W-1:0] empty_ofs_o,
  output logic [OFS_W-1:0] full_ofs_o
);

  localparam logic [31:0]      HALF32  = 32'(1) << (OFS_W - 1);
  localparam logic [OFS_W-1:0] HALF    = OFS_W'(HALF32);
  localparam logic [OFS_W-1:0] DEF_SER = OFS_W'(clamp_ofs(default_ofs(LOAD_SER), HALF32));
  localparam logic [OFS_W-1:0] DEF_PAR = OFS_W'(clamp_ofs(default_ofs(LOAD_PAR), HALF32));

  load_mode_e        cur_mode;
  load_mode_e        rst_mode;
  logic              par_wr;
  logic              ser_shift;
  logic              wr_to_m;
  logic [OFS_W-1:0]  ser_word;
  logic              ser_last_n;
  logic              ser_last_m;
  logic              load_n;
  logic              load_m;
  logic [OFS_W-1:0]  new_val;
  logic [OFS_W-1:0]  def_val;

  ofs_mode_latch u_mode (
    .clk    (clk),
    .mrst   (mrst),
    .sel_i  (load_sel_i),
    .mode_o (cur_mode)
  );

  assign serial_mode_o = (cur_mode == LOAD_SER);
  assign par_wr        = par_wr_i && !serial_mode_o;
  assign ser_shift     = ser_en_i && serial_mode_o;

  ofs_serial_shifter #(.OFS_W(OFS_W)) u_ser (
    .clk      (clk),
    .mrst     (mrst),
    .en_i     (ser_shift),
    .bit_i    (ser_bit_i),
    .word_o   (ser_word),
    .last_n_o (ser_last_n),
    .last_m_o (ser_last_m)
  );

  ofs_par_port #(.OFS_W(OFS_W)) u_par (
    .clk       (clk),
    .mrst      (mrst),
    .wr_i      (par_wr),
    .rd_i      (par_rd_i),
    .n_i       (empty_ofs_o),
    .m_i       (full_ofs_o),
    .wr_to_m_o (wr_to_m),
    .rdata_o   (par_rdata_o)
  );

  // Commit events for the two offset registers.
  assign load_n  = (par_wr && !wr_to_m) || ser_last_n;
  assign load_m  = (par_wr &&  wr_to_m) || ser_last_m;
  assign new_val = OFS_W'(clamp_ofs(32'(par_wr ? par_wdata_i : ser_word), HALF32));

  // Defaults follow the level sampled in the same reset cycle.
  assign rst_mode = load_sel_i ? LOAD_SER : LOAD_PAR;
  assign def_val  = (rst_mode == LOAD_SER) ? DEF_SER : DEF_PAR;

  always_ff @(posedge clk) begin
    if (mrst) begin
      empty_ofs_o <= def_val;
      full_ofs_o  <= def_val;
    end else begin
      if (load_n) empty_ofs_o <= new_val;
      if (load_m) full_ofs_o  <= new_val;
    end
  end

  // R2: serial defaults visible on the first cycle out of reset
  a_r2_serial_default: assert property (@(posedge clk) disable iff (mrst)
    ($fell(mrst) && serial_mode_o) |-> (empty_ofs_o == DEF_SER && full_ofs_o == DEF_SER));

  // R3: parallel defaults visible on the first cycle out of reset
  a_r3_parallel_default: assert property (@(posedge clk) disable iff (mrst)
    ($fell(mrst) && !serial_mode_o) |-> (empty_ofs_o == DEF_PAR && full_ofs_o == DEF_PAR));

  // R4: a write aimed at the empty offset leaves the full offset alone
  a_r4_empty_slot: assert property (@(posedge clk) disable iff (mrst)
    (par_wr && !wr_to_m) |=> $stable(full_ofs_o));

  // R4: a write aimed at the full offset leaves the empty offset alone
  a_r4_full_slot: assert property (@(posedge clk) disable iff (mrst)
    (par_wr && wr_to_m) |=> $stable(empty_ofs_o));

  // R5: shifting bits that are not the last of a word commits nothing
  a_r5_no_early_commit: assert property (@(posedge clk) disable iff (mrst)
    (ser_shift && !ser_last_n && !ser_last_m) |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

  // R7: both offsets stay within half the depth
  a_r7_ceiling: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |-> (empty_ofs_o <= HALF && full_ofs_o <= HALF));

  // R8: parallel strobes in serial mode change nothing
  a_r8_par_ignored: assert property (@(posedge clk) disable iff (mrst)
    (serial_mode_o && par_wr_i && !ser_en_i) |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

  // R8: serial clocks in parallel mode change nothing
  a_r8_ser_ignored: assert property (@(posedge clk) disable iff (mrst)
    (!serial_mode_o && ser_en_i && !par_wr_i) |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

endmodule

// File: tb/test_ofs_loader.sv
module test_ofs_loader;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 14;
  localparam int HALF       = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         mrst = 1'b1;
  logic         load_sel_i = 1'b0;
  logic         par_wr_i = 1'b0;
  logic [W-1:0] par_wdata_i = '0;
  logic         par_rd_i = 1'b0;
  logic [W-1:0] par_rdata_o;
  logic         ser_en_i = 1'b0;
  logic         ser_bit_i = 1'b0;
  logic         serial_mode_o;
  logic [W-1:0] empty_ofs_o;
  logic [W-1:0] full_ofs_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ofs_loader #(.OFS_W(W)) i_ofs_loader (
    .clk           (clk),
    .mrst          (mrst),
    .load_sel_i    (load_sel_i),
    .par_wr_i      (par_wr_i),
    .par_wdata_i   (par_wdata_i),
    .par_rd_i      (par_rd_i),
    .par_rdata_o   (par_rdata_o),
    .ser_en_i      (ser_en_i),
    .ser_bit_i     (ser_bit_i),
    .serial_mode_o (serial_mode_o),
    .empty_ofs_o   (empty_ofs_o),
    .full_ofs_o    (full_ofs_o)
  );

  function automatic int sat(input int v);
    if (v >= HALF) return HALF;
    return v;
  endfunction

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic chk_both(input string req, input int en, input int fm);
    chk(req, int'(empty_ofs_o), en);
    chk(req, int'(full_ofs_o), fm);
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    mrst = 1'b1;
    load_sel_i = sel;
    repeat (2) @(negedge clk);
    mrst = 1'b0;
  endtask

  task automatic pwrite(input int v);
    par_wr_i = 1'b1;
    par_wdata_i = W'(v);
    @(negedge clk);
    par_wr_i = 1'b0;
  endtask

  task automatic pread_step;
    par_rd_i = 1'b1;
    @(negedge clk);
    par_rd_i = 1'b0;
  endtask

  task automatic sbit(input logic b);
    ser_en_i = 1'b1;
    ser_bit_i = b;
    @(negedge clk);
    ser_en_i = 1'b0;
  endtask

  // Shift the low (W-1) bits of v; the caller sends the top bit.
  task automatic shift_head(input int v);
    for (int i = 0; i < W - 1; i++) sbit(v[i]);
  endtask

  task automatic t_serial_defaults;
    do_reset(1'b1);
    chk("R1", int'(serial_mode_o), 1);
    chk_both("R2", 'h3FF, 'h3FF);
    chk("R6", int'(par_rdata_o), 'h3FF);
  endtask

  task automatic t_serial_load;
    int v1 = 'h1234;
    int v2 = 'h2ABC;
    do_reset(1'b1);
    shift_head(v1);
    chk_both("R5", 'h3FF, 'h3FF);
    sbit(v1[W-1]);
    chk_both("R5", v1, 'h3FF);
    shift_head(v2);
    chk_both("R5", v1, 'h3FF);
    sbit(v2[W-1]);
    chk_both("R7", v1, sat(v2));
    chk("R6", int'(par_rdata_o), v1);
    pread_step();
    chk("R6", int'(par_rdata_o), HALF);
    pread_step();
    chk("R6", int'(par_rdata_o), v1);
    shift_head(5);
    sbit(1'b0);
    chk_both("R5", 5, HALF);
    pwrite('h0011);
    pwrite('h0022);
    chk_both("R8", 5, HALF);
    load_sel_i = 1'b0;
    @(negedge clk);
    chk("R1", int'(serial_mode_o), 1);
  endtask

  task automatic t_parallel;
    do_reset(1'b0);
    chk("R1", int'(serial_mode_o), 0);
    chk_both("R3", 'h7F, 'h7F);
    pwrite(100);
    chk_both("R4", 100, 'h7F);
    pwrite(200);
    chk_both("R4", 100, 200);
    pwrite(300);
    chk_both("R4", 300, 200);
    for (int i = 0; i < W; i++) sbit(1'b1);
    chk_both("R8", 300, 200);
    load_sel_i = 1'b1;
    @(negedge clk);
    chk("R1", int'(serial_mode_o), 0);
    pwrite(16383);
    chk_both("R7", 300, HALF);
    pwrite(HALF);
    chk_both("R7", HALF, HALF);
    pwrite(HALF - 1);
    chk_both("R7", HALF, HALF - 1);
  endtask

  task automatic t_readback;
    do_reset(1'b0);
    pwrite(11);
    pwrite(22);
    chk("R6", int'(par_rdata_o), 11);
    pread_step();
    chk("R6", int'(par_rdata_o), 22);
    pwrite(33);
    chk("R6", int'(par_rdata_o), 22);
    pread_step();
    chk("R6", int'(par_rdata_o), 33);
  endtask

  task automatic t_rereset;
    do_reset(1'b0);
    pwrite(50);
    pread_step();
    do_reset(1'b0);
    chk_both("R9", 'h7F, 'h7F);
    chk("R9", int'(par_rdata_o), 'h7F);
    pwrite(77);
    chk_both("R9", 77, 'h7F);
    chk("R9", int'(par_rdata_o), 77);
    do_reset(1'b1);
    shift_head(1);
    sbit(1'b0);
    do_reset(1'b1);
    chk_both("R9", 'h3FF, 'h3FF);
    shift_head(9);
    sbit(1'b0);
    chk_both("R9", 9, 'h3FF);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_serial_defaults();
    t_serial_load();
    t_parallel();
    t_readback();
    t_rereset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule